// File: doc/BRIEF.md
# SMT-Partitioned Return Address Stack

This block predicts return targets for two hardware threads that share one core. Every call a thread makes pushes its return address onto a stack. Every return pops the stack and gets the predicted target in the same cycle, with no register in the read path. The storage is one array of `2*HALF_DEPTH` entries. How the array is shared depends on whether both threads are running.

In dual mode both threads are in the active power state. Each thread then owns one half of the array and walks it with its own short pointer. Thread 0 uses entries `0..HALF_DEPTH-1` and thread 1 uses entries `HALF_DEPTH..2*HALF_DEPTH-1`. In solo mode one thread has asked to go idle. The remaining thread then uses the whole array through one wider pointer.

A change of mode never rewrites a stored entry. Only the pointers are remapped. As a result, the thread that stays active can be handed return targets that its sibling pushed just before the sibling went idle. The block reproduces this behaviour on purpose, so that the effect can be studied.

Top module: `smt_rap`

## Requirements
- R1: In dual mode thread 0 works only on entries 0..15 and thread 1 only on entries 16..31 (defaults). Each behaves as a last-in first-out stack, and the two threads do not disturb each other.
- R2: If `thr_idle` is 2'b10 (thread 1 idle) or 2'b01 (thread 0 idle) at a clock edge while in dual mode, the block enters solo mode at that edge. The non-idle thread becomes the active thread. The wide pointer becomes {active thread id, active thread's short pointer}.
- R3: In solo mode the active thread pushes and pops over all 32 entries through the 5-bit wide pointer. Its pops can read entries in the sibling's half.
- R4: If `thr_idle` is 2'b00 at an edge while in solo mode, the block returns to dual mode. Both short pointers take the low 4 bits of the wide pointer, and each thread keeps its own half.
- R5: A mode change leaves every stored entry unchanged.
- R6: Take the case where thread 1 has filled its half and thread 0's pointer is 0. A pop by thread 0 right after entering solo mode returns the entry at index 31, which is the value thread 1 pushed last.
- R7: Pushes wrap around within the active range and overwrite the oldest entries. Pops past the last valid entry return whatever stale value sits at the wrapped index. Entries carry no valid flag.
- R8: A push and a pop from the same enabled thread in one cycle return the pushed address on `pop_tgt`. The pushed address replaces the top entry, and the pointer does not change.
- R9: In solo mode, pushes and pops from the idle thread are ignored, and that thread's `pop_tgt` reads zero.
- R10: If `thr_idle` is 2'b11, the mode and the active thread hold their current values.
- R11: A synchronous active-high reset clears every pointer to zero and selects dual mode. It does not clear the array contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_idle | input | 2 | Bit t is 1 when thread t has left the active power state |
| push_vld | input | 2 | Bit t requests a call push by thread t |
| push_addr | input | 2 x ADDR_W | Return address pushed by each thread |
| pop_vld | input | 2 | Bit t requests a return pop by thread t |
| pop_tgt | output | 2 x ADDR_W | Predicted return target for each thread, valid in the same cycle |

## Verification
The mode-change properties assume that no thread pushes or pops in the cycle the mode changes. They only check cycles that meet this condition, and the stimulus never issues stack operations in a switching cycle. The assertions also assume that the idle inputs change only between edges. The bench drives every input on the falling edge and samples `pop_tgt` one nanosecond later. The array is never reset, so an expected value is checked only after the bench itself has written the entry being read.

// File: rtl/rap_pkg.sv
package rap_pkg;
   typedef enum logic {
      MODE_DUAL = 1'b0,
      MODE_SOLO = 1'b1
   } smt_mode_e;
endpackage

// File: rtl/rap_mode_ctl.sv
module rap_mode_ctl
   import rap_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] thr_idle,
   output smt_mode_e  mode,
   output logic       act,
   output logic       go_solo,
   output logic       go_dual,
   output logic       nxt_act
);
   smt_mode_e nxt_mode;

   always_comb begin
      nxt_mode = mode;
      nxt_act  = act;
      unique case (thr_idle)
         2'b00:   nxt_mode = MODE_DUAL;
         2'b01: begin nxt_mode = MODE_SOLO; nxt_act = 1'b1; end
         2'b10: begin nxt_mode = MODE_SOLO; nxt_act = 1'b0; end
         default: ;   // both idle: hold
      endcase
   end

   assign go_solo = (mode == MODE_DUAL) && (nxt_mode == MODE_SOLO);
   assign go_dual = (mode == MODE_SOLO) && (nxt_mode == MODE_DUAL);

   always_ff @(posedge clk) begin
      if (rst) begin
         mode <= MODE_DUAL;
         act  <= 1'b0;
      end else begin
         mode <= nxt_mode;
         act  <= nxt_act;
      end
   end
endmodule

// File: rtl/rap_ptr_unit.sv
module rap_ptr_unit
   import rap_pkg::*;
#(
   parameter  int PTR_W = 4,
   localparam int FPW   = PTR_W + 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  smt_mode_e             mode,
   input  logic                  act,
   input  logic                  go_solo,
   input  logic                  go_dual,
   input  logic                  nxt_act,
   input  logic [1:0]            push,
   input  logic [1:0]            pop,
   output logic [1:0]            en,
   output logic [1:0]            wen,
   output logic [1:0][FPW-1:0]   widx,
   output logic [1:0][FPW-1:0]   ridx,
   output logic [1:0][PTR_W-1:0] ptr,
   output logic [FPW-1:0]        fptr
);
   logic [1:0]            up, dn;
   logic [1:0][FPW-1:0]   cur;
   logic [1:0][PTR_W-1:0] ptr_n;
   logic [FPW-1:0]        fptr_n;

   for (genvar t = 0; t < 2; t++) begin : g_thr
      localparam logic TID = 1'(t);
      assign en[t]   = (mode == MODE_DUAL) || (act == TID);
      assign wen[t]  = en[t] & push[t];
      assign up[t]   = wen[t] & ~pop[t];
      assign dn[t]   = en[t] & pop[t] & ~push[t];
      assign cur[t]  = (mode == MODE_DUAL) ? {TID, ptr[t]} : fptr;
      assign ridx[t] = (mode == MODE_DUAL) ? {TID, ptr[t] - PTR_W'(1)}
                                           : fptr - FPW'(1);
      assign widx[t] = (en[t] & pop[t]) ? ridx[t] : cur[t];
   end

   always_comb begin
      ptr_n  = ptr;
      fptr_n = fptr;
      if (mode == MODE_DUAL) begin
         for (int t = 0; t < 2; t++) begin
            if (up[t])      ptr_n[t] = ptr[t] + PTR_W'(1);
            else if (dn[t]) ptr_n[t] = ptr[t] - PTR_W'(1);
         end
      end else begin
         if (|up)      fptr_n = fptr + FPW'(1);
         else if (|dn) fptr_n = fptr - FPW'(1);
      end
      if (go_solo) fptr_n = {nxt_act, ptr_n[nxt_act]};
      if (go_dual) begin
         for (int t = 0; t < 2; t++) ptr_n[t] = fptr_n[PTR_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr  <= '0;
         fptr <= '0;
      end else begin
         ptr  <= ptr_n;
         fptr <= fptr_n;
      end
   end
endmodule

// File: rtl/rap_store.sv
module rap_store #(
   parameter  int ADDR_W = 48,
   parameter  int DEPTH  = 32,
   localparam int IDX_W  = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic [1:0]             wen,
   input  logic [1:0][IDX_W-1:0]  widx,
   input  logic [1:0][ADDR_W-1:0] wdata,
   input  logic [1:0][IDX_W-1:0]  ridx,
   output logic [1:0][ADDR_W-1:0] rdata
);
   logic [ADDR_W-1:0] mem [DEPTH];

   // the two write ports never meet: halves differ in dual mode,
   // and only one thread is enabled in solo mode
   always_ff @(posedge clk) begin
      if (wen[0]) mem[widx[0]] <= wdata[0];
      if (wen[1]) mem[widx[1]] <= wdata[1];
   end

   for (genvar t = 0; t < 2; t++) begin : g_rd
      assign rdata[t] = mem[ridx[t]];
   end
endmodule

// File: rtl/smt_rap.sv
module smt_rap
   import rap_pkg::*;
#(
   parameter  int ADDR_W     = 48,
   parameter  int HALF_DEPTH = 16,
   localparam int PTR_W      = $clog2(HALF_DEPTH),
   localparam int FPW        = PTR_W + 1,
   localparam int DEPTH      = 2 * HALF_DEPTH
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [1:0]             thr_idle,
   input  logic [1:0]             push_vld,
   input  logic [1:0][ADDR_W-1:0] push_addr,
   input  logic [1:0]             pop_vld,
   output logic [1:0][ADDR_W-1:0] pop_tgt
);
   if (HALF_DEPTH < 2 || (HALF_DEPTH & (HALF_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("HALF_DEPTH must be a power of two of at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_width
      $error("ADDR_W must be positive");
   end

   smt_mode_e             mode;
   logic                  act, go_solo, go_dual, nxt_act, solo;
   logic [1:0]            en, wen;
   logic [1:0][FPW-1:0]   widx, ridx;
   logic [1:0][PTR_W-1:0] ptr;
   logic [FPW-1:0]        fptr;
   logic [1:0][ADDR_W-1:0] rdata;

   assign solo = (mode == MODE_SOLO);

   rap_mode_ctl u_mode (
      .clk, .rst, .thr_idle,
      .mode, .act, .go_solo, .go_dual, .nxt_act
   );

   rap_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
      .clk, .rst, .mode, .act, .go_solo, .go_dual, .nxt_act,
      .push(push_vld), .pop(pop_vld),
      .en, .wen, .widx, .ridx, .ptr, .fptr
   );

   rap_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
      .clk, .wen, .widx, .wdata(push_addr), .ridx, .rdata
   );

   for (genvar t = 0; t < 2; t++) begin : g_out
      always_comb begin
         if (!en[t])                      pop_tgt[t] = '0;
         else if (push_vld[t] && pop_vld[t]) pop_tgt[t] = push_addr[t];
         else                             pop_tgt[t] = rdata[t];
      end
   end
endmodule

// File: rtl/smt_rap_chk.sv
module smt_rap_chk #(
   parameter  int ADDR_W = 48,
   parameter  int PTR_W  = 4,
   localparam int FPW    = PTR_W + 1
) (
   input logic                   clk,
   input logic                   rst,
   input logic [1:0]             thr_idle,
   input logic [1:0]             push_vld,
   input logic [1:0][ADDR_W-1:0] push_addr,
   input logic [1:0]             pop_vld,
   input logic [1:0][ADDR_W-1:0] pop_tgt,
   input logic                   solo,
   input logic                   act,
   input logic [1:0][PTR_W-1:0]  ptr,
   input logic [FPW-1:0]         fptr
);
   a_r11_reset_state: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!solo && ptr == '0 && fptr == '0));

   a_r2_enter_solo: assert property (@(posedge clk) disable iff (rst)
      (!solo && thr_idle == 2'b10 && push_vld == 2'b00 && pop_vld == 2'b00)
      |=> (solo && !act && fptr == {1'b0, $past(ptr[0])}));

   a_r4_leave_solo: assert property (@(posedge clk) disable iff (rst)
      (solo && thr_idle == 2'b00 && push_vld == 2'b00 && pop_vld == 2'b00)
      |=> (!solo && ptr[0] == $past(fptr[PTR_W-1:0])
                 && ptr[1] == $past(fptr[PTR_W-1:0])));

   a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      (thr_idle == 2'b11) |=> (solo == $past(solo) && act == $past(act)));

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      solo |-> (pop_tgt[~act] == '0));

   a_r8_bypass_t0: assert property (@(posedge clk) disable iff (rst)
      (push_vld[0] && pop_vld[0] && (!solo || !act)) |-> (pop_tgt[0] == push_addr[0]));

   a_r8_bypass_t1: assert property (@(posedge clk) disable iff (rst)
      (push_vld[1] && pop_vld[1] && (!solo || act)) |-> (pop_tgt[1] == push_addr[1]));
endmodule

bind smt_rap smt_rap_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst(rst), .thr_idle(thr_idle), .push_vld(push_vld),
   .push_addr(push_addr), .pop_vld(pop_vld), .pop_tgt(pop_tgt),
   .solo(solo), .act(act), .ptr(ptr), .fptr(fptr)
);

// File: tb/sim_smt_rap.sv
module sim_smt_rap;
   localparam int AW = 48;
   localparam int HD = 16;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [1:0] idle = '0, pv = '0, qv = '0;
   logic [1:0][AW-1:0] pa = '0;
   logic [1:0][AW-1:0] pt;
   int n_run = 0, n_fail = 0;

   always #2 clk = ~clk;   // 250 MHz

   smt_rap #(.ADDR_W(AW), .HALF_DEPTH(HD)) u0 (
      .clk(clk), .rst(rst), .thr_idle(idle), .push_vld(pv),
      .push_addr(pa), .pop_vld(qv), .pop_tgt(pt)
   );

   typedef struct packed {
      logic [1:0]  idle;
      logic [1:0]  push;
      logic [1:0]  pop;
      logic [15:0] a0;
      logic [15:0] a1;
      logic [1:0]  chk;
      logic [15:0] e0;
      logic [15:0] e1;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VT [NV] = '{
      '{2'b00, 2'b11, 2'b00, 16'h0A1, 16'h0B1, 2'b00, 16'h0,   16'h0,   4'd1 },  // R1 fill
      '{2'b00, 2'b11, 2'b00, 16'h0A2, 16'h0B2, 2'b00, 16'h0,   16'h0,   4'd1 },
      '{2'b00, 2'b00, 2'b11, 16'h0,   16'h0,   2'b11, 16'h0A2, 16'h0B2, 4'd1 },  // R1 LIFO, split
      '{2'b00, 2'b00, 2'b01, 16'h0,   16'h0,   2'b01, 16'h0A1, 16'h0,   4'd1 },
      '{2'b00, 2'b10, 2'b10, 16'h0,   16'h0BB, 2'b10, 16'h0,   16'h0BB, 4'd8 },  // R8 bypass
      '{2'b01, 2'b00, 2'b00, 16'h0,   16'h0,   2'b00, 16'h0,   16'h0,   4'd2 },  // R2 to solo, t1
      '{2'b01, 2'b11, 2'b01, 16'h0DD, 16'h0C1, 2'b01, 16'h0,   16'h0,   4'd9 },  // R9 idle t0 ignored
      '{2'b01, 2'b00, 2'b11, 16'h0,   16'h0,   2'b11, 16'h0,   16'h0C1, 4'd3 },  // R3 solo stack
      '{2'b11, 2'b00, 2'b00, 16'h0,   16'h0,   2'b00, 16'h0,   16'h0,   4'd10},  // R10 both idle
      '{2'b11, 2'b00, 2'b01, 16'h0,   16'h0,   2'b01, 16'h0,   16'h0,   4'd10},  // R10 still solo
      '{2'b00, 2'b00, 2'b00, 16'h0,   16'h0,   2'b00, 16'h0,   16'h0,   4'd4 },  // R4 back to dual
      '{2'b00, 2'b00, 2'b11, 16'h0,   16'h0,   2'b11, 16'h0A1, 16'h0BB, 4'd4 },  // R4 remap, R5
      '{2'b10, 2'b00, 2'b00, 16'h0,   16'h0,   2'b00, 16'h0,   16'h0,   4'd2 },  // R2 to solo, t0
      '{2'b10, 2'b01, 2'b00, 16'h0A7, 16'h0,   2'b00, 16'h0,   16'h0,   4'd3 },
      '{2'b10, 2'b00, 2'b01, 16'h0,   16'h0,   2'b01, 16'h0A7, 16'h0,   4'd3 }
   };

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   task automatic apply(input logic [1:0] i, input logic [1:0] p, input logic [1:0] q,
                        input logic [AW-1:0] a0, input logic [AW-1:0] a1);
      @(negedge clk);
      idle = i; pv = p; qv = q; pa[0] = a0; pa[1] = a1;
      #1;
   endtask

   task automatic check(input int thr, input logic [AW-1:0] exp, input string req);
      n_run++;
      if (pt[thr] !== exp) begin
         n_fail++;
         $display("FAIL %s thread %0d: actual %h expected %h", req, thr, pt[thr], exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; idle = '0; pv = '0; qv = '0; pa = '0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      do_reset();

      // table walk: R1, R2, R3, R4, R5, R8, R9, R10
      for (int k = 0; k < NV; k++) begin
         apply(VT[k].idle, VT[k].push, VT[k].pop, AW'(VT[k].a0), AW'(VT[k].a1));
         if (VT[k].chk[0]) check(0, AW'(VT[k].e0), $sformatf("R%0d", VT[k].req));
         if (VT[k].chk[1]) check(1, AW'(VT[k].e1), $sformatf("R%0d", VT[k].req));
      end

      // R6: thread 1 fills its half, thread 0 takes over and pops at once
      do_reset();
      for (int i = 0; i < HD; i++) apply(2'b00, 2'b10, 2'b00, '0, AW'(48'h100 + i));
      apply(2'b10, 2'b00, 2'b00, '0, '0);
      apply(2'b10, 2'b00, 2'b01, '0, '0);
      check(0, AW'(48'h10F), "R6");
      apply(2'b10, 2'b00, 2'b01, '0, '0);
      check(0, AW'(48'h10E), "R3");
      // R5: back to dual, pointers 14; thread 1 reads its untouched entry 29
      apply(2'b00, 2'b00, 2'b00, '0, '0);
      apply(2'b00, 2'b00, 2'b10, '0, '0);
      check(1, AW'(48'h10D), "R5");

      // R11: pointers cleared, array kept (index 31 still holds 0x10F)
      do_reset();
      apply(2'b00, 2'b00, 2'b10, '0, '0);
      check(1, AW'(48'h10F), "R11");

      // R7: 18 pushes into a 16-entry half, then 17 pops
      do_reset();
      for (int i = 0; i < HD + 2; i++) apply(2'b00, 2'b01, 2'b00, AW'(48'h200 + i), '0);
      for (int i = 1; i <= HD + 1; i++) begin
         apply(2'b00, 2'b00, 2'b01, '0, '0);
         if (i == 1)      check(0, AW'(48'h211), "R7");
         if (i == 2)      check(0, AW'(48'h210), "R7");
         if (i == HD)     check(0, AW'(48'h202), "R7");
         if (i == HD + 1) check(0, AW'(48'h211), "R7");
      end

      apply(2'b00, 2'b00, 2'b00, '0, '0);
      summary();
      $finish;
   end
endmodule